// File: doc/BRIEF.md
# Tiled View Address Generator

This block maps a pixel position inside a tiled two-dimensional container to a 32-bit address whose upper bits select the pixel format and the view orientation. Each request carries a format code, a 3-bit orientation code and X/Y coordinates. The block can mirror either axis and can swap the axes, so the same buffer can be read rotated by 90, 180 or 270 degrees, with or without mirroring. It then packs the coordinates into a linear offset and scales that offset by the pixel size. Alongside the address it reports the row stride that applies to the chosen orientation.

Requests enter through a valid/ready handshake and leave through a single registered output stage with its own valid/ready pair. A two-state machine controls that stage. In `ST_EMPTY` the stage is free and any request is accepted (transition *fill*, to `ST_FULL`). In `ST_FULL`, a low `out_ready` keeps the state (transition *stall*). A high `out_ready` with a new request loads it at once (transition *replace*, staying in `ST_FULL`). A high `out_ready` with no request returns the stage to `ST_EMPTY` (transition *drain*).

Top module: `tiled_view_addr`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: For an accepted in-range 2D request, address bits [31:29] equal the orientation code and bits [28:27] equal the format code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page).
- R3: The axis shifts (xs, ys) are (0,0) for 8-bit, (0,1) for 16-bit and (1,1) for 32-bit. X has 14−xs bits and Y has 13−ys bits. Without a swap, bits [26:0] equal ((Y << xbits) + X) << (xs+ys).
- R4: Orientation bit 0 replaces X with X XOR its full mask. Orientation bit 1 does the same for Y with the Y mask. Both are applied before packing.
- R5: When orientation bit 2 is set, the packed offset is (X << ybits) + Y instead.
- R6: If X exceeds its mask or Y exceeds its mask, the address is 0 and `out_err` is 0.
- R7: Format 3 (page) yields address 0, stride 0 and `out_err` 1.
- R8: For a 2D format, the stride is 1 << (13 + xs) when orientation bit 2 is set, and 1 << (14 + ys) otherwise. This holds even when the coordinates are out of range.
- R9: While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values and `in_ready` is 0.
- R10: A request accepted at a clock edge appears on the outputs right after that edge. Back-to-back requests with `out_ready` high are accepted one per cycle. With no new request, a drained stage drops `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_fmt | input | 2 | Pixel format code |
| in_orient | input | 3 | Orientation: bit0 mirror X, bit1 mirror Y, bit2 swap axes |
| in_x | input | 16 | X coordinate in pixels |
| in_y | input | 16 | Y coordinate in pixels |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Tiled address |
| out_stride | output | 16 | Row stride in bytes for the chosen orientation |
| out_err | output | 1 | Request used the page format |

## Verification
The hardest situation to reach from the ports is a *replace* transition. In that case, a held result is released and a waiting request is loaded in the same edge, while the request itself has been stalled behind a blocked consumer for several cycles. The stimulus gets there by lowering `out_ready` and loading one request. It then presents a second request while the first is stuck and checks both the hold and the closed `in_ready`. Finally it raises `out_ready` with the second request still asserted, so that the drain and the load happen together. Combined mirror-and-swap codes at the coordinate extremes are exercised through the vector table, because they reach the widest offsets.

// File: rtl/tva_pkg.sv
package tva_pkg;

    typedef enum logic [1:0] {
        FMT_B8   = 2'd0,
        FMT_B16  = 2'd1,
        FMT_B32  = 2'd2,
        FMT_PAGE = 2'd3
    } fmt_e;

    localparam int ORI_XINV = 0;
    localparam int ORI_YINV = 1;
    localparam int ORI_SWAP = 2;

    typedef struct packed {
        logic [1:0] xs;
        logic [1:0] ys;
        logic       is_2d;
    } geom_t;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;

endpackage

// File: rtl/tva_geom.sv
module tva_geom
    import tva_pkg::*;
(
    input  logic [1:0] fmt,
    output geom_t      geom
);

    always_comb begin
        geom = '0;
        unique case (fmt_e'(fmt))
            FMT_B8:   geom = '{xs: 2'd0, ys: 2'd0, is_2d: 1'b1};
            FMT_B16:  geom = '{xs: 2'd0, ys: 2'd1, is_2d: 1'b1};
            FMT_B32:  geom = '{xs: 2'd1, ys: 2'd1, is_2d: 1'b1};
            FMT_PAGE: geom = '{xs: 2'd0, ys: 2'd0, is_2d: 1'b0};
        endcase
    end

endmodule

// File: rtl/tva_map.sv
module tva_map
    import tva_pkg::*;
#(
    parameter int CW_BITS  = 14,
    parameter int CH_BITS  = 13,
    parameter int COORD_W  = 16,
    parameter int OFF_W    = CW_BITS + CH_BITS,
    parameter int ADDR_W   = OFF_W + 5,
    parameter int STRIDE_W = 16
)(
    input  logic [1:0]          fmt,
    input  geom_t               geom,
    input  logic [2:0]          orient,
    input  logic [COORD_W-1:0]  x,
    input  logic [COORD_W-1:0]  y,
    output logic [ADDR_W-1:0]   addr,
    output logic [STRIDE_W-1:0] stride,
    output logic                err
);

    localparam int SH_W = 6;

    logic [SH_W-1:0]    xbits, ybits, align, st_sh;
    logic [COORD_W-1:0] xmask, ymask, xm, ym;
    logic [OFF_W-1:0]   xw, yw, packed_off, off;
    logic               in_range;

    always_comb begin
        xbits = SH_W'(CW_BITS) - SH_W'(geom.xs);
        ybits = SH_W'(CH_BITS) - SH_W'(geom.ys);
        align = SH_W'(geom.xs) + SH_W'(geom.ys);

        xmask = (COORD_W'(1) << xbits) - COORD_W'(1);
        ymask = (COORD_W'(1) << ybits) - COORD_W'(1);
        in_range = (x <= xmask) && (y <= ymask);

        xm = orient[ORI_XINV] ? (x ^ xmask) : x;
        ym = orient[ORI_YINV] ? (y ^ ymask) : y;
        xw = OFF_W'(xm);
        yw = OFF_W'(ym);

        if (orient[ORI_SWAP])
            packed_off = (xw << ybits) + yw;
        else
            packed_off = (yw << xbits) + xw;
        off = packed_off << align;

        if (geom.is_2d && in_range)
            addr = {orient, fmt, off};
        else
            addr = '0;

        st_sh = orient[ORI_SWAP] ? (SH_W'(CH_BITS) + SH_W'(geom.xs))
                                 : (SH_W'(CW_BITS) + SH_W'(geom.ys));
        stride = geom.is_2d ? (STRIDE_W'(1) << st_sh) : '0;
        err    = !geom.is_2d;
    end

endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr
    import tva_pkg::*;
#(
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13,
    parameter int COORD_W = 16,
    localparam int OFF_W    = CW_BITS + CH_BITS,
    localparam int ADDR_W   = OFF_W + 5,
    localparam int STRIDE_W = ((CW_BITS > CH_BITS) ? CW_BITS : CH_BITS) + 2
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [1:0]          in_fmt,
    input  logic [2:0]          in_orient,
    input  logic [COORD_W-1:0]  in_x,
    input  logic [COORD_W-1:0]  in_y,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [STRIDE_W-1:0] out_stride,
    output logic                out_err
);

    stage_e              state, state_nx;
    geom_t               geom;
    logic [ADDR_W-1:0]   addr_c;
    logic [STRIDE_W-1:0] stride_c;
    logic                err_c;
    logic                accept;

    tva_geom u_geom (
        .fmt  (in_fmt),
        .geom (geom)
    );

    tva_map #(
        .CW_BITS  (CW_BITS),
        .CH_BITS  (CH_BITS),
        .COORD_W  (COORD_W),
        .OFF_W    (OFF_W),
        .ADDR_W   (ADDR_W),
        .STRIDE_W (STRIDE_W)
    ) u_map (
        .fmt    (in_fmt),
        .geom   (geom),
        .orient (in_orient),
        .x      (in_x),
        .y      (in_y),
        .addr   (addr_c),
        .stride (stride_c),
        .err    (err_c)
    );

    assign accept = in_valid && in_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (accept) state_nx = ST_FULL;
            ST_FULL:  if (out_ready && !accept) state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr   <= '0;
            out_stride <= '0;
            out_err    <= 1'b0;
        end else if (accept) begin
            out_addr   <= addr_c;
            out_stride <= stride_c;
            out_err    <= err_c;
        end
    end

    always_comb begin
        out_valid = (state == ST_FULL);
        in_ready  = (state == ST_EMPTY) || out_ready;
    end

endmodule

// File: rtl/tva_chk.sv
module tva_chk #(
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 16
)(
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [ADDR_W-1:0]   out_addr,
    input logic [STRIDE_W-1:0] out_stride,
    input logic                out_err
);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr)
                                    && $stable(out_stride) && $stable(out_err));

    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);

    a_r7_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err |-> (out_addr == '0) && (out_stride == '0));

    a_r8_stride_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_err |-> $countones(out_stride) == 1);

    a_r2_no_page_field: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_addr != '0) |-> out_addr[ADDR_W-4:ADDR_W-5] != 2'd3);

endmodule

bind tiled_view_addr tva_chk #(
    .ADDR_W   (ADDR_W),
    .STRIDE_W (STRIDE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_addr   (out_addr),
    .out_stride (out_stride),
    .out_err    (out_err)
);

// File: tb/tiled_view_addr_tb.sv
module tiled_view_addr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_fmt = '0;
    logic [2:0]  in_orient = '0;
    logic [15:0] in_x = '0;
    logic [15:0] in_y = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic [15:0] out_stride;
    logic        out_err;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tiled_view_addr u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_fmt(in_fmt), .in_orient(in_orient), .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_stride(out_stride), .out_err(out_err)
    );

    // {fmt, orient, x, y, expected addr, expected stride, expected err}
    localparam int NV = 13;
    localparam logic [85:0] VEC [NV] = '{
        {2'd0, 3'd0, 16'h0005, 16'h0003, 32'h0000C005, 16'h4000, 1'b0},
        {2'd1, 3'd0, 16'h0005, 16'h0003, 32'h0801800A, 16'h8000, 1'b0},
        {2'd2, 3'd0, 16'h0005, 16'h0003, 32'h10018014, 16'h8000, 1'b0},
        {2'd0, 3'd1, 16'h0005, 16'h0003, 32'h2000FFFA, 16'h4000, 1'b0},
        {2'd0, 3'd2, 16'h0005, 16'h0003, 32'h47FF0005, 16'h4000, 1'b0},
        {2'd0, 3'd4, 16'h0005, 16'h0003, 32'h8000A003, 16'h2000, 1'b0},
        {2'd2, 3'd6, 16'h0005, 16'h0003, 32'hD0017FF0, 16'h4000, 1'b0},
        {2'd1, 3'd7, 16'h0010, 16'h0020, 32'hEFFDFFBE, 16'h2000, 1'b0},
        {2'd0, 3'd0, 16'h3FFF, 16'h1FFF, 32'h07FFFFFF, 16'h4000, 1'b0},
        {2'd1, 3'd0, 16'h0000, 16'h1000, 32'h00000000, 16'h8000, 1'b0},
        {2'd2, 3'd0, 16'h2000, 16'h0000, 32'h00000000, 16'h8000, 1'b0},
        {2'd3, 3'd0, 16'h0001, 16'h0001, 32'h00000000, 16'h0000, 1'b1},
        {2'd2, 3'd3, 16'h1FFF, 16'h0FFF, 32'h70000000, 16'h8000, 1'b0}
    };

    function automatic string vec_tag(int i);
        case (i)
            3, 4, 12:  return "R4";
            5, 6, 7:   return "R5";
            9, 10:     return "R6";
            11:        return "R7";
            default:   return "R3";
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(logic [85:0] v);
        in_fmt    = v[85:84];
        in_orient = v[83:81];
        in_x      = v[80:65];
        in_y      = v[64:49];
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 in_ready", 64'(in_ready), 64'd1);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            in_valid  = 1'b1;
            out_ready = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk("R10 valid", 64'(out_valid), 64'd1);
            chk(vec_tag(i), 64'(out_addr), 64'(VEC[i][48:17]));
            chk("R8 stride", 64'(out_stride), 64'(VEC[i][16:1]));
            chk("R7 err", 64'(out_err), 64'(VEC[i][0]));
            if (VEC[i][48:17] != 32'd0)
                chk("R2 fields", 64'(out_addr[31:27]), 64'({VEC[i][83:81], VEC[i][85:84]}));
        end
        @(negedge clk);
        chk("R10 drained", 64'(out_valid), 64'd0);

        // stall with a waiting request, then replace
        out_ready = 1'b0;
        drive(VEC[0]);
        in_valid = 1'b1;
        @(negedge clk);
        drive(VEC[5]);
        chk("R9 in_ready low", 64'(in_ready), 64'd0);
        repeat (3) @(negedge clk);
        chk("R9 hold valid", 64'(out_valid), 64'd1);
        chk("R9 hold addr", 64'(out_addr), 64'h0000C005);
        chk("R9 hold stride", 64'(out_stride), 64'h4000);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 replace addr", 64'(out_addr), 64'h8000A003);
        chk("R10 replace valid", 64'(out_valid), 64'd1);
        @(negedge clk);
        chk("R10 drain", 64'(out_valid), 64'd0);

        // back-to-back
        drive(VEC[1]);
        in_valid = 1'b1;
        @(negedge clk);
        chk("R10 b2b first", 64'(out_addr), 64'h0801800A);
        drive(VEC[2]);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 b2b second", 64'(out_addr), 64'h10018014);
        chk("R10 b2b valid", 64'(out_valid), 64'd1);
        @(negedge clk);
        chk("R10 b2b drain", 64'(out_valid), 64'd0);

        // reset while full
        drive(VEC[3]);
        in_valid  = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule